// File: doc/BRIEF.md
# I/O Window Address Translator

This bridge sits between a CPU load/store port and a byte-addressed I/O bus. CPU accesses inside a fixed 8 MB window are turned into I/O port addresses and sent downstream with their size and data. Accesses outside the window finish at once and never reach the I/O bus.

There are two address mappings, chosen by a map-select input. In contiguous mode the low 16 bits of the window offset are the port number. In sparse mode the five low address bits are kept and offset bits [26:12] are moved down by seven places. This lets software put each group of 32 ports on its own 4 KB page.

A parameter sets the CPU byte order. With big-endian ordering, the bridge swaps the byte lanes of halfword and word data in both directions. Byte data is never swapped.

The CPU side uses a valid/ready request and a one-cycle completion strobe. The I/O side uses a valid/ready request and a read-return strobe. Only one access is in flight at a time, and the CPU side stays busy until the access completes.

Top module: `io_window_bridge`

## Requirements
- R1: A CPU request whose address bits [31:23] differ from those of the window base (default 0x80000000) issues no I/O request. It completes with `cpu_done` in the cycle after acceptance, with `cpu_rdata` equal to 0.
- R2: With `map_sparse` = 0, `io_addr` equals CPU address bits [15:0], and `io_addr` bits [19:16] are zero.
- R3: With `map_sparse` = 1, `io_addr` equals (offset bits [4:0]) OR (offset bits [26:12] shifted right by 7). Here the offset is the CPU address with the window base bits cleared. For example, 0x80123456 gives 0x2476.
- R4: The mapping mode is sampled when the CPU request is accepted. Changing `map_sparse` later has no effect on an access already accepted.
- R5: Size code 0 is a byte, 1 a halfword, and 2 or 3 a word. The code is forwarded unchanged on `io_size`. A byte write drives `cpu_wdata[7:0]` on `io_wdata[7:0]`, and a byte read returns `io_rdata[7:0]` on `cpu_rdata[7:0]`. Unused upper lanes are zero in both directions.
- R6: With big-endian ordering, halfword data has its two bytes exchanged on writes (`io_wdata[15:0]` = {wdata[7:0], wdata[15:8]}) and on reads. Bits [31:16] are zero.
- R7: With big-endian ordering, word data has its four bytes reversed on writes and reads (byte 0 goes to byte 3, and so on).
- R8: With little-endian ordering, halfword and word data pass with lanes unchanged. Only the lanes above the access size are zeroed.
- R9: `cpu_ready` is high only when no access is in flight. Once `io_valid` rises, it stays high with `io_addr`, `io_we`, `io_size` and `io_wdata` stable until `io_ready` is seen.
- R10: A write completes with `cpu_done` in the cycle after the I/O handshake. A read completes in the cycle after `io_rvalid`, carrying that cycle's data. `cpu_done` lasts one cycle.
- R11: During and just after reset, `cpu_ready` = 1, `io_valid` = 0 and `cpu_done` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| map_sparse | input | 1 | Map select: 0 contiguous, 1 sparse |
| cpu_valid | input | 1 | CPU request valid |
| cpu_ready | output | 1 | Bridge can accept a request |
| cpu_we | input | 1 | 1 write, 0 read |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| cpu_addr | input | 32 | CPU physical address |
| cpu_wdata | input | 32 | CPU write data, byte-lane aligned to bit 0 |
| cpu_done | output | 1 | One-cycle completion strobe |
| cpu_rdata | output | 32 | Read data, valid with `cpu_done` |
| io_valid | output | 1 | I/O request valid |
| io_ready | input | 1 | I/O bus accepts the request |
| io_we | output | 1 | I/O write flag |
| io_size | output | 2 | I/O access size code |
| io_addr | output | 20 | Translated port address |
| io_wdata | output | 32 | Lane-ordered write data |
| io_rvalid | input | 1 | Read data return strobe |
| io_rdata | input | 32 | Read data from I/O bus |

## Verification
The bench builds two copies side by side from the same CPU stimulus and the same I/O responder. One uses the default big-endian ordering and the other uses little-endian ordering. With both copies, every vector checks the swapped and the pass-through lane paths in the same run, so the byte/halfword/word cases of R5 to R8 are all reached. The default window base and map shift constants are kept. This puts the top edge of the window, the first address past it, and sparse addresses whose dropped bits [11:5] are set within reach of the directed tests. A responder with a fixed three-cycle read delay and a switchable ready makes read-completion timing and request holding observable.

// File: rtl/io_win_pkg.sv
// Package io_win_pkg
// Shared constants and types for the I/O window bridge.
// Assumes a 32-bit CPU data path carried as four byte lanes.
package io_win_pkg;
    localparam int DATA_W  = 32;
    localparam int LANES   = DATA_W / 8;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } bridge_state_e;
endpackage

// File: rtl/io_win_xlate.sv
// Module io_win_xlate
// Purely combinational window decode and port-address translation.
// Assumes the window is a power-of-two region aligned to its size and
// that the sparse field lies inside a 32-bit address.
module io_win_xlate #(
    parameter logic [31:0] WIN_BASE     = 32'h8000_0000,
    parameter int          WIN_LOG2     = 23,
    parameter int          CONTIG_BITS  = 16,
    parameter int          KEEP_BITS    = 5,
    parameter int          SPARSE_HI    = 26,
    parameter int          SPARSE_LO    = 12,
    parameter int          SPARSE_SHIFT = 7,
    parameter int          PORT_W       = SPARSE_HI - SPARSE_SHIFT + 1
) (
    input  logic [31:0]       addr,
    input  logic              sparse,
    output logic              hit,
    output logic [PORT_W-1:0] port
);
    localparam logic [31:0] WIN_MASK    = (32'd1 << WIN_LOG2) - 32'd1;
    localparam logic [31:0] CONTIG_MASK = (32'd1 << CONTIG_BITS) - 32'd1;
    localparam logic [31:0] KEEP_MASK   = (32'd1 << KEEP_BITS) - 32'd1;
    localparam logic [31:0] FIELD_MASK  =
        ((32'd1 << (SPARSE_HI + 1)) - 32'd1) & ~((32'd1 << SPARSE_LO) - 32'd1);

    logic [31:0] offset;
    logic [31:0] contig_full;
    logic [31:0] sparse_full;

    // Split the address into window tag compare and in-window offset.
    always_comb begin
        hit    = ((addr ^ WIN_BASE) & ~WIN_MASK) == 32'd0;
        offset = addr & WIN_MASK;
    end

    // Build both candidate port numbers and pick one by map mode.
    always_comb begin
        contig_full = offset & CONTIG_MASK;
        sparse_full = (offset & KEEP_MASK) | ((offset & FIELD_MASK) >> SPARSE_SHIFT);
        port        = sparse ? PORT_W'(sparse_full) : PORT_W'(contig_full);
    end
endmodule

// File: rtl/io_win_lanes.sv
// Module io_win_lanes
// Size-aware byte-lane steering. Zeroes lanes above the access size and,
// for big-endian ordering, reverses the bytes inside the access.
// The same logic serves write and read data since the swap is its own inverse.
module io_win_lanes
    import io_win_pkg::*;
#(
    parameter bit BIG_ENDIAN = 1'b1
) (
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] half_v;
    logic [DATA_W-1:0] word_v;

    generate
        if (BIG_ENDIAN) begin : g_swap
            // Exchange the two bytes of a halfword and reverse all lanes of a word.
            always_comb begin
                half_v = {16'd0, din[7:0], din[15:8]};
                for (int i = 0; i < LANES; i++) begin
                    word_v[8*i +: 8] = din[8*(LANES-1-i) +: 8];
                end
            end
        end else begin : g_pass
            // Keep lane order; only mask the halfword case.
            always_comb begin
                half_v = {16'd0, din[15:0]};
                word_v = din;
            end
        end
    endgenerate

    // Select the steering that matches the access size.
    always_comb begin
        case (size)
            SZ_BYTE: dout = {24'd0, din[7:0]};
            SZ_HALF: dout = half_v;
            default: dout = word_v;
        endcase
    end
endmodule

// File: rtl/io_win_ctrl.sv
// Module io_win_ctrl
// Single-outstanding access sequencer. Captures a translated request on
// acceptance, presents it to the I/O bus until taken, waits for read data,
// then strobes completion back to the CPU side.
// Assumes io_rvalid arrives only for an issued read.
module io_win_ctrl
    import io_win_pkg::*;
#(
    parameter int PORT_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_we,
    input  logic [1:0]        cpu_size,
    input  logic              hit,
    input  logic [PORT_W-1:0] port_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic [DATA_W-1:0] rdata_in,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              io_valid,
    input  logic              io_ready,
    output logic              io_we,
    output logic [1:0]        io_size,
    output logic [PORT_W-1:0] io_addr,
    output logic [DATA_W-1:0] io_wdata,
    input  logic              io_rvalid
);
    bridge_state_e state;

    // Handshake outputs follow the sequencer state.
    always_comb begin
        cpu_ready = (state == ST_IDLE);
        io_valid  = (state == ST_ISSUE);
        cpu_done  = (state == ST_RESP);
    end

    // Sequence one access from acceptance through completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            io_we     <= 1'b0;
            io_size   <= SZ_BYTE;
            io_addr   <= '0;
            io_wdata  <= '0;
            cpu_rdata <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (cpu_valid) begin
                        io_we     <= cpu_we;
                        io_size   <= cpu_size;
                        io_addr   <= port_in;
                        io_wdata  <= wdata_in;
                        cpu_rdata <= '0;
                        state     <= hit ? ST_ISSUE : ST_RESP;
                    end
                end
                ST_ISSUE: begin
                    if (io_ready) begin
                        state <= io_we ? ST_RESP : ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (io_rvalid) begin
                        cpu_rdata <= rdata_in;
                        state     <= ST_RESP;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Out-of-window access never reaches the I/O bus (R1).
    assert_miss_local_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_ready && !hit) |=> (cpu_done && !io_valid && cpu_rdata == '0));

    // A pending request holds its fields until taken (R9).
    assert_hold_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid && !io_ready) |=> (io_valid && $stable(io_addr) && $stable(io_wdata)
                                     && $stable(io_size) && $stable(io_we)));

    // An I/O request only starts from an accepted in-window access (R9).
    assert_issue_origin_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(io_valid) |-> $past(cpu_valid && cpu_ready && hit));

    // Completion is a single-cycle strobe (R10).
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    // A read does not complete before its data returns (R10).
    assert_read_waits_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !io_rvalid) |=> !cpu_done);
endmodule

// File: rtl/io_window_bridge.sv
// Module io_window_bridge
// Top of the I/O window bridge: window decode and port translation,
// write/read lane steering and the access sequencer.
// Assumes one CPU access in flight at a time.
module io_window_bridge
    import io_win_pkg::*;
#(
    parameter logic [31:0] WIN_BASE     = 32'h8000_0000,
    parameter int          WIN_LOG2     = 23,
    parameter int          CONTIG_BITS  = 16,
    parameter int          KEEP_BITS    = 5,
    parameter int          SPARSE_HI    = 26,
    parameter int          SPARSE_LO    = 12,
    parameter int          SPARSE_SHIFT = 7,
    parameter bit          BIG_ENDIAN   = 1'b1,
    localparam int         PORT_W       = SPARSE_HI - SPARSE_SHIFT + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_sparse,
    input  logic              cpu_valid,
    output logic              cpu_ready,
    input  logic              cpu_we,
    input  logic [1:0]        cpu_size,
    input  logic [31:0]       cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              io_valid,
    input  logic              io_ready,
    output logic              io_we,
    output logic [1:0]        io_size,
    output logic [PORT_W-1:0] io_addr,
    output logic [DATA_W-1:0] io_wdata,
    input  logic              io_rvalid,
    input  logic [DATA_W-1:0] io_rdata
);
    logic              hit;
    logic [PORT_W-1:0] port;
    logic [DATA_W-1:0] wdata_lanes;
    logic [DATA_W-1:0] rdata_lanes;

    io_win_xlate #(
        .WIN_BASE    (WIN_BASE),
        .WIN_LOG2    (WIN_LOG2),
        .CONTIG_BITS (CONTIG_BITS),
        .KEEP_BITS   (KEEP_BITS),
        .SPARSE_HI   (SPARSE_HI),
        .SPARSE_LO   (SPARSE_LO),
        .SPARSE_SHIFT(SPARSE_SHIFT),
        .PORT_W      (PORT_W)
    ) u_xlate (
        .addr  (cpu_addr),
        .sparse(map_sparse),
        .hit   (hit),
        .port  (port)
    );

    io_win_lanes #(.BIG_ENDIAN(BIG_ENDIAN)) u_wlanes (
        .size(cpu_size),
        .din (cpu_wdata),
        .dout(wdata_lanes)
    );

    io_win_lanes #(.BIG_ENDIAN(BIG_ENDIAN)) u_rlanes (
        .size(io_size),
        .din (io_rdata),
        .dout(rdata_lanes)
    );

    io_win_ctrl #(.PORT_W(PORT_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_valid(cpu_valid),
        .cpu_we   (cpu_we),
        .cpu_size (cpu_size),
        .hit      (hit),
        .port_in  (port),
        .wdata_in (wdata_lanes),
        .rdata_in (rdata_lanes),
        .cpu_ready(cpu_ready),
        .cpu_done (cpu_done),
        .cpu_rdata(cpu_rdata),
        .io_valid (io_valid),
        .io_ready (io_ready),
        .io_we    (io_we),
        .io_size  (io_size),
        .io_addr  (io_addr),
        .io_wdata (io_wdata),
        .io_rvalid(io_rvalid)
    );
endmodule

// File: tb/test_io_window_bridge.sv
`timescale 1ns/1ps
module test_io_window_bridge;
    localparam int RD_LAT = 3;

    typedef struct packed {
        logic [31:0] addr;
        logic        we;
        logic [1:0]  size;
        logic        sparse;
        logic [31:0] wdata;
        logic [31:0] resp;
        logic [19:0] port;
        logic [31:0] exp_be;
        logic [31:0] exp_le;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{32'h8000_0061, 1'b1, 2'd0, 1'b0, 32'hDEAD_BE5A, 32'h0, 20'h00061, 32'h0000_005A, 32'h0000_005A},
        '{32'h8000_1234, 1'b1, 2'd1, 1'b0, 32'hFFFF_1122, 32'h0, 20'h01234, 32'h0000_2211, 32'h0000_1122},
        '{32'h8012_3456, 1'b1, 2'd2, 1'b0, 32'h1122_3344, 32'h0, 20'h03456, 32'h4433_2211, 32'h1122_3344},
        '{32'h8000_1013, 1'b0, 2'd0, 1'b1, 32'h0,         32'hAABB_CCDD, 20'h00033, 32'h0000_00DD, 32'h0000_00DD},
        '{32'h8012_3456, 1'b0, 2'd1, 1'b1, 32'h0,         32'hAABB_CCDD, 20'h02476, 32'h0000_DDCC, 32'h0000_CCDD},
        '{32'h807F_FFFC, 1'b0, 2'd2, 1'b0, 32'h0,         32'h0102_0304, 20'h0FFFC, 32'h0403_0201, 32'h0102_0304},
        '{32'h807F_F01F, 1'b1, 2'd2, 1'b1, 32'hCAFE_F00D, 32'h0, 20'h0FFFF, 32'h0DF0_FECA, 32'hCAFE_F00D},
        '{32'h8000_0800, 1'b0, 2'd2, 1'b1, 32'h0,         32'h5566_7788, 20'h00000, 32'h8877_6655, 32'h5566_7788},
        '{32'h8000_0398, 1'b1, 2'd3, 1'b0, 32'hA1B2_C3D4, 32'h0, 20'h00398, 32'hD4C3_B2A1, 32'hA1B2_C3D4}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        map_sparse = 1'b0;
    logic        cpu_valid = 1'b0;
    logic        cpu_we = 1'b0;
    logic [1:0]  cpu_size = 2'd0;
    logic [31:0] cpu_addr = 32'h0;
    logic [31:0] cpu_wdata = 32'h0;
    logic        io_ready = 1'b1;
    logic        io_rvalid = 1'b0;
    logic [31:0] io_rdata = 32'h0;

    logic        cpu_ready, cpu_done, io_valid, io_we;
    logic [1:0]  io_size;
    logic [19:0] io_addr;
    logic [31:0] cpu_rdata, io_wdata;
    logic        cpu_ready_le, cpu_done_le, io_valid_le, io_we_le;
    logic [1:0]  io_size_le;
    logic [19:0] io_addr_le;
    logic [31:0] cpu_rdata_le, io_wdata_le;

    int          errors = 0;
    int          checks = 0;
    int          hs_count = 0;
    int          rd_wait = 0;
    logic [31:0] resp_word = 32'h0;
    logic [19:0] cap_addr, cap_addr_le;
    logic [31:0] cap_wdata, cap_wdata_le;
    logic [1:0]  cap_size;
    logic        cap_we;

    always #2.5 clk = ~clk;

    io_window_bridge i_io_window_bridge (
        .clk(clk), .rst_n(rst_n), .map_sparse(map_sparse),
        .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_we(cpu_we),
        .cpu_size(cpu_size), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .io_valid(io_valid), .io_ready(io_ready), .io_we(io_we),
        .io_size(io_size), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rvalid(io_rvalid), .io_rdata(io_rdata)
    );

    io_window_bridge #(.BIG_ENDIAN(1'b0)) i_io_window_bridge_le (
        .clk(clk), .rst_n(rst_n), .map_sparse(map_sparse),
        .cpu_valid(cpu_valid), .cpu_ready(cpu_ready_le), .cpu_we(cpu_we),
        .cpu_size(cpu_size), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_done(cpu_done_le), .cpu_rdata(cpu_rdata_le),
        .io_valid(io_valid_le), .io_ready(io_ready), .io_we(io_we_le),
        .io_size(io_size_le), .io_addr(io_addr_le), .io_wdata(io_wdata_le),
        .io_rvalid(io_rvalid), .io_rdata(io_rdata)
    );

    // I/O bus model: record each handshake, return read data after RD_LAT cycles.
    always @(posedge clk) begin
        io_rvalid <= 1'b0;
        if (!rst_n) begin
            rd_wait <= 0;
        end else begin
            if (io_valid && io_ready) begin
                hs_count     <= hs_count + 1;
                cap_addr     <= io_addr;
                cap_addr_le  <= io_addr_le;
                cap_wdata    <= io_wdata;
                cap_wdata_le <= io_wdata_le;
                cap_size     <= io_size;
                cap_we       <= io_we;
                if (!io_we) rd_wait <= RD_LAT;
            end else if (rd_wait > 1) begin
                rd_wait <= rd_wait - 1;
            end else if (rd_wait == 1) begin
                rd_wait   <= 0;
                io_rvalid <= 1'b1;
                io_rdata  <= resp_word;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Issue one access and wait for completion; lat counts edges from acceptance.
    task automatic do_access(input logic [31:0] a, input logic w, input logic [1:0] s,
                             input logic sp, input logic [31:0] wd, input logic [31:0] rsp,
                             output logic [31:0] rd_be, output logic [31:0] rd_le,
                             output int lat);
        @(negedge clk);
        resp_word  = rsp;
        cpu_addr   = a;
        cpu_we     = w;
        cpu_size   = s;
        cpu_wdata  = wd;
        map_sparse = sp;
        cpu_valid  = 1'b1;
        lat = 0;
        for (int i = 0; i < 100; i++) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (lat == 1) cpu_valid = 1'b0;
            if (cpu_done) break;
        end
        rd_be = cpu_rdata;
        rd_le = cpu_rdata_le;
        if (!cpu_done) check("R10 completion seen", 32'd0, 32'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [31:0] rb, rl;
        int          lat, hs0;

        repeat (3) @(negedge clk);
        // R11: state while reset is held
        check("R11 cpu_ready in reset", {31'd0, cpu_ready}, 32'd1);
        check("R11 io_valid in reset", {31'd0, io_valid}, 32'd0);
        check("R11 cpu_done in reset", {31'd0, cpu_done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 cpu_ready after reset", {31'd0, cpu_ready}, 32'd1);
        check("R11 io_valid after reset", {31'd0, io_valid}, 32'd0);

        // Vector table walk: translation and lane steering in both orderings.
        for (int v = 0; v < NVEC; v++) begin
            hs0 = hs_count;
            do_access(VECS[v].addr, VECS[v].we, VECS[v].size, VECS[v].sparse,
                      VECS[v].wdata, VECS[v].resp, rb, rl, lat);
            check("R1 in-window forwarded", hs_count - hs0, 32'd1);
            check(VECS[v].sparse ? "R3 sparse port" : "R2 contiguous port",
                  {12'd0, cap_addr}, {12'd0, VECS[v].port});
            check("R5 size forwarded", {30'd0, cap_size}, {30'd0, VECS[v].size});
            if (VECS[v].we) begin
                check(VECS[v].size == 2'd0 ? "R5 byte write" :
                      VECS[v].size == 2'd1 ? "R6 half write" : "R7 word write",
                      cap_wdata, VECS[v].exp_be);
                check("R8 little-endian write", cap_wdata_le, VECS[v].exp_le);
                check("R10 write latency", lat, 32'd2);
            end else begin
                check(VECS[v].size == 2'd0 ? "R5 byte read" :
                      VECS[v].size == 2'd1 ? "R6 half read" : "R7 word read",
                      rb, VECS[v].exp_be);
                check("R8 little-endian read", rl, VECS[v].exp_le);
                check("R10 read latency", lat, RD_LAT + 3);
            end
        end

        // R1: just below and just past the window
        hs0 = hs_count;
        do_access(32'h7FFF_FFFC, 1'b0, 2'd2, 1'b0, 32'h0, 32'hFFFF_FFFF, rb, rl, lat);
        check("R1 below window no request", hs_count - hs0, 32'd0);
        check("R1 below window rdata", rb, 32'h0);
        check("R1 below window latency", lat, 32'd1);
        do_access(32'h8080_0000, 1'b1, 2'd2, 1'b1, 32'h1234_5678, 32'h0, rb, rl, lat);
        check("R1 past window no request", hs_count - hs0, 32'd0);
        check("R1 past window rdata", rb, 32'h0);

        // R9 and R4: back-pressure, with the map mode flipped after acceptance
        @(negedge clk);
        io_ready   = 1'b0;
        resp_word  = 32'h0BAD_F00D;
        cpu_addr   = 32'h8012_3456;
        cpu_we     = 1'b0;
        cpu_size   = 2'd2;
        map_sparse = 1'b1;
        cpu_valid  = 1'b1;
        @(negedge clk);
        cpu_valid  = 1'b0;
        map_sparse = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R9 io_valid held", {31'd0, io_valid}, 32'd1);
            check("R9 cpu_ready low while busy", {31'd0, cpu_ready}, 32'd0);
            check("R4 held port keeps sparse mode", {12'd0, io_addr}, 32'h2476);
        end
        io_ready = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (cpu_done) break;
        end
        check("R4 captured port", {12'd0, cap_addr}, 32'h2476);
        check("R10 read after back-pressure", cpu_rdata, 32'h0DF0_AD0B);
        @(negedge clk);
        check("R10 done is one cycle", {31'd0, cpu_done}, 32'd0);
        check("R9 ready again", {31'd0, cpu_ready}, 32'd1);

        finish_run();
    end
endmodule